// File: doc/BRIEF.md
# H-Bridge Short-Circuit Protection Sequencer

This block supervises an H-bridge for output shorts and over-temperature. Each bridge switch has a short-detect flag from an external drain-source comparator, and each flag is paired with a command bit that says whether the gate controller is driving that switch on. A short is counted only while its switch is commanded on. When the counted short persists for a filter window, the block disables the bridge for a timed off period and then lets it run again for one retry. The bridge-enable input decides what happens next. In latch mode a short that is confirmed again during the retry parks the bridge in a latched standby. In auto mode the block keeps alternating between a longer off period and a retry for as long as the short remains.

The latched standby is cleared only by a power-on reset or by driving the bridge-enable input (`ps`) low. While `ps` is low, every timer is held cleared and the bridge is disabled. A thermal flag from an external comparator with its own hysteresis disables the bridge for exactly as long as it is set. The thermal flag also pulls the active-low warning output, which is shared with short protection. All timer lengths are parameters in clock cycles.

The state machine has five states. IDLE: `ps` is low or the block has just been reset. ARMED: normal running, with the filter active. SHORT_OFF: the bridge is off while the off timer runs. RETRY: the bridge is back on and the block watches for a repeat short. LATCHED: standby until `ps` goes low.

The transitions are:
- IDLE→ARMED when `ps` is high.
- ARMED→SHORT_OFF when a short is confirmed.
- SHORT_OFF→RETRY when the off timer expires.
- RETRY→ARMED after a quiet window with no counted short.
- RETRY→LATCHED on a confirmed short in latch mode.
- RETRY→SHORT_OFF on a confirmed short in auto mode.
- any state→IDLE while `ps` is low.

Top module: `short_guard`

## Requirements
- R1: After reset, and whenever `ps` is low, `bridge_off`=1 and `standby_latched`=0, with `warn_n`=1 unless the thermal flag is set. `bridge_off` goes to 0 one clock after `ps` is sampled high.
- R2: A counted short (short flag of a switch AND its `sw_on` bit, thermal clear) confirms only when it is sampled high on FILT_CYC consecutive rising edges. `bridge_off` rises on that edge. A shorter run has no effect, and a drop restarts the count.
- R3: A short flag whose switch has `sw_on`=0 never confirms, whatever its length.
- R4: After a confirmation with `mode_auto`=0, `bridge_off` stays 1 for exactly RETRY_CYC clocks and then returns to 0 (retry).
- R5: With `mode_auto`=0, a short confirmed again during the retry sets `standby_latched`=1 and `bridge_off`=1. Both hold for as long as `ps` stays high.
- R6: `ps` sampled low clears `standby_latched` on the next clock. Raising `ps` again re-arms normal operation.
- R7: FILT_CYC consecutive clocks with no counted short during the retry return the block to normal running. A later short then gets a fresh off period rather than an immediate latch.
- R8: With `mode_auto`=1, the off period lasts AUTO_CYC clocks. A short that persists causes repeated off and retry cycles, and `standby_latched` never rises.
- R9: `warn_n` is 0 during the off period, the retry and the latched standby, and while the thermal flag is set. It returns to 1 in the same clock that normal running resumes.
- R10: The thermal flag drives `bridge_off`=1 and `warn_n`=0 combinationally while set. Its clearing restores both combinationally. Shorts are not counted during thermal shutdown, and it never latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ps | input | 1 | Bridge enable; low forces standby and clears the latch |
| mode_auto | input | 1 | 0 = latch after failed retry, 1 = keep retrying |
| sw_on | input | N_SW | Per-switch gate command (1 = switch driven on) |
| short_det | input | N_SW | Per-switch short-detect comparator flags |
| therm_flag | input | 1 | Thermal shutdown comparator flag |
| bridge_off | output | 1 | 1 = all bridge switches must be off |
| standby_latched | output | 1 | 1 = latched short-circuit standby |
| warn_n | output | 1 | Active-low warning (open-drain style) |

## Verification
Effects of `ps` low and of the thermal flag reach `bridge_off` and `warn_n` combinationally. The bench samples these 1 ns after it drives them. Every state-driven result appears one rising edge after the sample that decides it:
- a confirmation on the FILT_CYC-th high sample;
- the retry on the RETRY_CYC-th or AUTO_CYC-th clock of the off period;
- a latch or a re-arm on the FILT_CYC-th sample of the retry.

The bench drives inputs just after a falling edge and checks at the falling edge that follows the counted number of rising edges. It checks the cycle before each expected change as well as the change itself. The run-length sweep covers every length from 1 to FILT_CYC+2, and every switch is tried with its command bit off and on.

// File: rtl/short_guard_pkg.sv
package short_guard_pkg;

    typedef enum logic [2:0] {
        SG_IDLE      = 3'd0,
        SG_ARMED     = 3'd1,
        SG_SHORT_OFF = 3'd2,
        SG_RETRY     = 3'd3,
        SG_LATCHED   = 3'd4
    } sg_state_t;

    function automatic int sg_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sg_qualify.sv
module sg_qualify #(
    parameter int N_SW = 4
) (
    input  logic [N_SW-1:0] sw_on,
    input  logic [N_SW-1:0] short_det,
    input  logic            therm_flag,
    output logic            short_any
);
    logic [N_SW-1:0] hit;

    // A flag counts only for a switch that is currently commanded on.
    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        assign hit[i] = short_det[i] & sw_on[i];
    end

    // During thermal shutdown the bridge is forced off, so no short is counted.
    assign short_any = (|hit) & ~therm_flag;
endmodule

// File: rtl/sg_counter.sv
module sg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_TOP = '1;

    // Clear takes priority over increment; the count saturates at its top.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
    import short_guard_pkg::*;
#(
    parameter int FILT_CYC  = 500,
    parameter int RETRY_CYC = 2500,
    parameter int AUTO_CYC  = 250000,
    parameter int CW        = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ps,
    input  logic          mode_auto,
    input  logic          short_any,
    input  logic          therm_flag,
    input  logic [CW-1:0] pc_cnt,
    input  logic [CW-1:0] tc_cnt,
    output logic          pc_clr,
    output logic          pc_inc,
    output logic          tc_clr,
    output logic          tc_inc,
    output logic          bridge_off,
    output logic          standby_latched,
    output logic          warn_n
);
    localparam logic [CW-1:0] FILT_LAST  = CW'(FILT_CYC - 1);
    localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);
    localparam logic [CW-1:0] AUTO_LAST  = CW'(AUTO_CYC - 1);

    sg_state_t     state, state_nx;
    logic [CW-1:0] off_last;

    assign off_last = mode_auto ? AUTO_LAST : RETRY_LAST;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SG_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and counter control
    always_comb begin
        state_nx = state;
        pc_clr   = 1'b0;
        pc_inc   = 1'b0;
        tc_clr   = 1'b0;
        tc_inc   = 1'b0;
        if (!ps) begin
            state_nx = SG_IDLE;
            pc_clr   = 1'b1;
            tc_clr   = 1'b1;
        end else begin
            unique case (state)
                SG_IDLE: begin
                    state_nx = SG_ARMED;
                    pc_clr   = 1'b1;
                    tc_clr   = 1'b1;
                end
                SG_ARMED: begin
                    tc_clr = 1'b1;
                    if (short_any) begin
                        if (pc_cnt == FILT_LAST) begin
                            state_nx = SG_SHORT_OFF;
                            pc_clr   = 1'b1;
                        end else begin
                            pc_inc = 1'b1;
                        end
                    end else begin
                        pc_clr = 1'b1;
                    end
                end
                SG_SHORT_OFF: begin
                    pc_clr = 1'b1;
                    if (tc_cnt >= off_last) begin
                        state_nx = SG_RETRY;
                        tc_clr   = 1'b1;
                    end else begin
                        tc_inc = 1'b1;
                    end
                end
                SG_RETRY: begin
                    if (short_any) begin
                        tc_clr = 1'b1;
                        if (pc_cnt == FILT_LAST) begin
                            state_nx = mode_auto ? SG_SHORT_OFF : SG_LATCHED;
                            pc_clr   = 1'b1;
                        end else begin
                            pc_inc = 1'b1;
                        end
                    end else begin
                        pc_clr = 1'b1;
                        if (tc_cnt == FILT_LAST) begin
                            state_nx = SG_ARMED;
                            tc_clr   = 1'b1;
                        end else begin
                            tc_inc = 1'b1;
                        end
                    end
                end
                SG_LATCHED: begin
                    pc_clr = 1'b1;
                    tc_clr = 1'b1;
                end
                default: begin
                    state_nx = SG_IDLE;
                    pc_clr   = 1'b1;
                    tc_clr   = 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        bridge_off      = 1'b1;
        standby_latched = 1'b0;
        warn_n          = 1'b1;
        unique case (state)
            SG_IDLE:      bridge_off = 1'b1;
            SG_ARMED:     bridge_off = 1'b0;
            SG_SHORT_OFF: begin
                bridge_off = 1'b1;
                warn_n     = 1'b0;
            end
            SG_RETRY: begin
                bridge_off = 1'b0;
                warn_n     = 1'b0;
            end
            SG_LATCHED: begin
                bridge_off      = 1'b1;
                standby_latched = 1'b1;
                warn_n          = 1'b0;
            end
            default:      bridge_off = 1'b1;
        endcase
        if (!ps || therm_flag) begin
            bridge_off = 1'b1;
        end
        if (therm_flag) begin
            warn_n = 1'b0;
        end
    end

    // R1: PS low holds the sequencer idle with its filter cleared
    a_r1_ps_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ps |=> (state == SG_IDLE && pc_cnt == '0 && tc_cnt == '0));

    // R2: leaving normal running requires a full run of counted samples
    a_r2_confirm_after_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_ARMED && state_nx == SG_SHORT_OFF) |-> (short_any && pc_cnt == FILT_LAST));

    // R4: the off timer never runs past its limit
    a_r4_off_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_SHORT_OFF) |-> (tc_cnt <= off_last));

    // R5: latched standby persists while PS stays high
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_LATCHED && ps) |=> (state == SG_LATCHED));

    // R8: auto mode never enters latched standby from the retry
    a_r8_auto_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_RETRY && mode_auto) |=> (state != SG_LATCHED));
endmodule

// File: rtl/short_guard.sv
module short_guard
    import short_guard_pkg::*;
#(
    parameter int N_SW      = 4,
    parameter int FILT_CYC  = 500,
    parameter int RETRY_CYC = 2500,
    parameter int AUTO_CYC  = 250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ps,
    input  logic            mode_auto,
    input  logic [N_SW-1:0] sw_on,
    input  logic [N_SW-1:0] short_det,
    input  logic            therm_flag,
    output logic            bridge_off,
    output logic            standby_latched,
    output logic            warn_n
);
    localparam int MAX_CYC = sg_max3(FILT_CYC, RETRY_CYC, AUTO_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic          short_any;
    logic          pc_clr, pc_inc, tc_clr, tc_inc;
    logic [CW-1:0] pc_cnt, tc_cnt;

    sg_qualify #(.N_SW(N_SW)) u_qual (
        .sw_on      (sw_on),
        .short_det  (short_det),
        .therm_flag (therm_flag),
        .short_any  (short_any)
    );

    sg_counter #(.W(CW)) u_pcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pc_clr),
        .inc   (pc_inc),
        .cnt   (pc_cnt)
    );

    sg_counter #(.W(CW)) u_tcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tc_clr),
        .inc   (tc_inc),
        .cnt   (tc_cnt)
    );

    sg_fsm #(
        .FILT_CYC  (FILT_CYC),
        .RETRY_CYC (RETRY_CYC),
        .AUTO_CYC  (AUTO_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .ps              (ps),
        .mode_auto       (mode_auto),
        .short_any       (short_any),
        .therm_flag      (therm_flag),
        .pc_cnt          (pc_cnt),
        .tc_cnt          (tc_cnt),
        .pc_clr          (pc_clr),
        .pc_inc          (pc_inc),
        .tc_clr          (tc_clr),
        .tc_inc          (tc_inc),
        .bridge_off      (bridge_off),
        .standby_latched (standby_latched),
        .warn_n          (warn_n)
    );

    // R9: the warning is already on in the cycle before a latch is entered
    a_r9_warn_before_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_latched) |-> $past(!warn_n));
endmodule

// File: tb/short_guard_tb.sv
module short_guard_tb;
    localparam int N_SW  = 4;
    localparam int FILT  = 4;
    localparam int RETRY = 10;
    localparam int AUTO  = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ps = 1'b0;
    logic            mode_auto = 1'b0;
    logic [N_SW-1:0] sw_on = '0;
    logic [N_SW-1:0] short_det = '0;
    logic            therm_flag = 1'b0;
    logic            bridge_off, standby_latched, warn_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    short_guard #(
        .N_SW(N_SW), .FILT_CYC(FILT), .RETRY_CYC(RETRY), .AUTO_CYC(AUTO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ps(ps), .mode_auto(mode_auto),
        .sw_on(sw_on), .short_det(short_det), .therm_flag(therm_flag),
        .bridge_off(bridge_off), .standby_latched(standby_latched), .warn_n(warn_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic rearm();
        ps = 1'b0;
        short_det = '0;
        tick(1);
        ps = 1'b1;
        tick(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(2);
        check("R1", "bridge_off in reset", bridge_off, 1'b1);
        check("R1", "standby in reset", standby_latched, 1'b0);
        check("R1", "warn_n in reset", warn_n, 1'b1);
        rst_n = 1'b1;
        tick(2);
        check("R1", "bridge_off ps low", bridge_off, 1'b1);
        ps = 1'b1;
        tick(1);
        check("R1", "bridge_off after ps rise", bridge_off, 1'b0);
        sw_on = '1;

        // R2: sweep run length; confirmation only at FILT consecutive samples
        for (int n = 1; n <= FILT + 2; n++) begin
            short_det = 4'b0001;
            for (int k = 1; k <= n; k++) begin
                tick(1);
                check("R2", $sformatf("run %0d cycle %0d", n, k), bridge_off, (k >= FILT) ? 1'b1 : 1'b0);
            end
            short_det = '0;
            tick(FILT + 1);
            check("R2", $sformatf("after run %0d", n), bridge_off, (n >= FILT) ? 1'b1 : 1'b0);
            rearm();
        end

        // R2: a drop restarts the persistence count
        short_det = 4'b0100;
        tick(FILT - 1);
        short_det = '0;
        tick(1);
        short_det = 4'b0100;
        tick(FILT - 1);
        check("R2", "restart after drop", bridge_off, 1'b0);
        tick(1);
        check("R2", "confirm after restart", bridge_off, 1'b1);
        rearm();

        // R3: flags of switches commanded off are ignored
        for (int i = 0; i < N_SW; i++) begin
            sw_on = ~(4'b0001 << i);
            short_det = 4'b0001 << i;
            tick(FILT + 3);
            check("R3", $sformatf("switch %0d off", i), bridge_off, 1'b0);
            check("R3", $sformatf("switch %0d off warn", i), warn_n, 1'b1);
            sw_on = '1;
            tick(FILT);
            check("R2", $sformatf("switch %0d on confirms", i), bridge_off, 1'b1);
            rearm();
        end

        // R4/R5: latch-mode off period, retry, latch
        mode_auto = 1'b0;
        short_det = 4'b0010;
        tick(FILT);
        check("R4", "off after confirm", bridge_off, 1'b1);
        check("R9", "warn in off", warn_n, 1'b0);
        tick(RETRY - 1);
        check("R4", "still off at RETRY-1", bridge_off, 1'b1);
        tick(1);
        check("R4", "retry on at RETRY", bridge_off, 1'b0);
        check("R9", "warn in retry", warn_n, 1'b0);
        tick(FILT - 1);
        check("R5", "not latched before FILT", standby_latched, 1'b0);
        tick(1);
        check("R5", "latched", standby_latched, 1'b1);
        check("R5", "latched off", bridge_off, 1'b1);
        check("R9", "warn latched", warn_n, 1'b0);
        short_det = '0;
        tick(50);
        check("R5", "latch holds", standby_latched, 1'b1);
        check("R5", "latch holds off", bridge_off, 1'b1);

        // R6: ps low clears latch
        ps = 1'b0;
        tick(1);
        check("R6", "latch cleared", standby_latched, 1'b0);
        check("R6", "warn released", warn_n, 1'b1);
        check("R1", "off while ps low", bridge_off, 1'b1);
        ps = 1'b1;
        tick(1);
        check("R6", "rearmed", bridge_off, 1'b0);

        // R7: quiet retry returns to normal; a new short starts a fresh off period
        short_det = 4'b1000;
        tick(FILT);
        short_det = '0;
        tick(RETRY);
        check("R7", "in retry", bridge_off, 1'b0);
        tick(FILT - 1);
        check("R7", "warn during quiet", warn_n, 1'b0);
        tick(1);
        check("R7", "warn released after quiet", warn_n, 1'b1);
        short_det = 4'b1000;
        tick(FILT);
        check("R7", "fresh off", bridge_off, 1'b1);
        check("R7", "not latched", standby_latched, 1'b0);
        tick(RETRY);
        check("R7", "fresh retry", bridge_off, 1'b0);
        rearm();

        // R8: auto mode repeats and never latches
        mode_auto = 1'b1;
        short_det = 4'b0001;
        tick(FILT);
        check("R8", "auto first off", bridge_off, 1'b1);
        for (int r = 0; r < 3; r++) begin
            tick(AUTO - 1);
            check("R8", $sformatf("auto off %0d held", r), bridge_off, 1'b1);
            tick(1);
            check("R8", $sformatf("auto retry %0d", r), bridge_off, 1'b0);
            check("R8", $sformatf("auto no latch %0d", r), standby_latched, 1'b0);
            tick(FILT - 1);
            check("R8", $sformatf("auto retry %0d held", r), bridge_off, 1'b0);
            tick(1);
            check("R8", $sformatf("auto re-off %0d", r), bridge_off, 1'b1);
            check("R8", $sformatf("auto re-off no latch %0d", r), standby_latched, 1'b0);
        end
        short_det = '0;
        tick(AUTO);
        check("R8", "auto final retry", bridge_off, 1'b0);
        tick(FILT - 1);
        check("R9", "warn before quiet end", warn_n, 1'b0);
        tick(1);
        check("R9", "warn released auto", warn_n, 1'b1);
        mode_auto = 1'b0;

        // R10: thermal shutdown
        therm_flag = 1'b1;
        #1;
        check("R10", "therm off", bridge_off, 1'b1);
        check("R10", "therm warn", warn_n, 1'b0);
        short_det = 4'b0010;
        tick(FILT + 5);
        therm_flag = 1'b0;
        short_det = '0;
        #1;
        check("R10", "therm restore", bridge_off, 1'b0);
        check("R10", "therm warn release", warn_n, 1'b1);
        check("R10", "therm no latch", standby_latched, 1'b0);
        tick(2);
        check("R10", "no short confirmed during therm", bridge_off, 1'b0);

        finish_run();
    end
endmodule